// File: doc/BRIEF.md
# Multi-Mode Reloading Down-Counter Timer

This block is a 16-bit down-counter with a reload register. The counter steps down by one on each count pulse. A pulse that finds the counter at zero is an underflow. On underflow the counter takes the reload value again and the underflow request output pulses. A reload value of n therefore gives an underflow every n+1 count pulses.

A 2-bit mode field picks the source of the count pulses and decides whether an external pin also restarts the count:

- **Free-running timer:** pulses come from the clock divided by a prescaler.
- **Event counter:** pulses come from one chosen edge of the pin.
- **Period meter:** the same prescaled pulses run the counter, and one chosen pin edge restarts it from the reload value. On that edge the value the counter held just before the restart is saved in a capture register.
- **High/low width meter:** as the period meter, but both pin edges restart the counter and save a capture.

Software reaches the block through a small word-wide register port. Writes land on the rising clock edge. Reads are combinational and follow the address.

Top module: `rld_timer`

## Requirements
- R1: After reset the counter and reload register read 0xFFFF, the control word reads 0x0000 (running, free-running timer, edge bit 0), the capture register reads 0x0000, and both request outputs are low.
- R2: The register port is word-wide and decodes `addr` as follows. Address 0 writes the reload register and reads the counter. Address 1 is the control word. Address 2 reads the capture register. Address 3 reads the reload register.
- R3: In the control word, bits 5:4 are the mode: 00 free-running timer, 01 period meter, 10 event counter, 11 high/low width meter. Bit 6 is the edge select and bit 7 is the halt bit. All other bits read back as 0.
- R4: In timer mode the counter steps down once every 16 clocks, with the first step 16 clocks after counting is enabled. With reload value n, after d steps the counter reads n − (d mod (n+1)).
- R5: A count pulse that finds the counter at 0 reloads it from the reload register and raises `irq_uf` for exactly one clock. With reload value n, d steps give floor(d/(n+1)) underflow pulses.
- R6: In event mode the counter steps on rising pin edges when the edge select is 0 and on falling edges when it is 1. Edges of the other polarity do not count. Each pin edge takes effect on the third rising clock edge after the pin changes.
- R7: In period mode the valid edge is falling for edge select 0 and rising for edge select 1. A valid edge reloads the counter and captures its prior value. If a prescaler step falls on the same clock as a valid edge, the edge wins. Edges of the other polarity leave the capture and the counter alone. A capture is held until the next valid edge.
- R8: In width mode both pin edges reload and capture, whatever the edge select holds.
- R9: `irq_edge` pulses for one clock on each valid pin edge in every mode. Outside width mode the valid edge is the one chosen by the edge select. In width mode both edges are valid.
- R10: While the halt bit is 1, the counter does not step, the prescaler restarts from zero, and pin edges neither count nor capture.
- R11: A write of the reload register while halted also loads the counter. A write while counting changes only the reload register, and the new value takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| we | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data, combinational |
| ext_pin | input | 1 | Asynchronous external input |
| irq_uf | output | 1 | One-clock underflow request |
| irq_edge | output | 1 | One-clock valid-edge request |

## Verification
The bench drives random reload values, including 0, and random run lengths in timer mode. A counter that reloaded one pulse early, or that counted its prescaler from the wrong clock, would show a wrong value or a wrong underflow count.

Capture timing is checked to the exact cycle. This includes the three-clock pin latency and the point where a prescaler step could fall beside an edge. A design that captured after the decrement, or that let the wrong polarity restart the count, would store a different word.

The bench also checks behaviour that should not happen. Halted counters must not drift. A running reload write must wait for the next underflow. In width mode both edges must be honoured while the edge select is 0.

// File: rtl/rld_timer.sv
`timescale 1ns/1ps
module rld_timer #(
  parameter int W        = 16,
  parameter int PRESCALE = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         ext_pin,
  output logic         irq_uf,
  output logic         irq_edge
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [W-1:0]  latch_q, cnt_q, cap_q;
  logic [1:0]    mode_q;
  logic          edge_q, stop_q;
  logic [PW-1:0] pre_q;
  logic [2:0]    sync_q;
  logic          irq_uf_q, irq_edge_q;

  logic rise, fall, valid_edge, evt_edge, tick, pulse, meas_hit, uf;
  logic wr_latch, wr_ctrl;

  assign rise       = sync_q[1] & ~sync_q[2];
  assign fall       = ~sync_q[1] & sync_q[2];
  assign valid_edge = (mode_q == 2'b11) ? (rise | fall) : (edge_q ? rise : fall);
  assign evt_edge   = edge_q ? fall : rise;
  assign tick       = (pre_q == PW'(PRESCALE - 1));
  assign pulse      = !stop_q && ((mode_q == 2'b10) ? evt_edge : tick);
  assign meas_hit   = !stop_q && mode_q[0] && valid_edge;
  assign uf         = pulse && (cnt_q == '0) && !meas_hit;
  assign wr_latch   = we && (addr == 2'd0);
  assign wr_ctrl    = we && (addr == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre_q <= '0;
    else if (stop_q || tick) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      edge_q <= 1'b0;
      stop_q <= 1'b0;
    end else if (wr_ctrl) begin
      mode_q <= wdata[5:4];
      edge_q <= wdata[6];
      stop_q <= wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '1;
    else if (wr_latch) latch_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '1;
    else if (wr_latch && stop_q) cnt_q <= wdata;
    else if (meas_hit)           cnt_q <= latch_q;
    else if (pulse)              cnt_q <= (cnt_q == '0) ? latch_q : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_q <= '0;
    else if (meas_hit) cap_q <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_uf_q   <= 1'b0;
      irq_edge_q <= 1'b0;
    end else begin
      irq_uf_q   <= uf;
      irq_edge_q <= valid_edge;
    end
  end

  assign irq_uf   = irq_uf_q;
  assign irq_edge = irq_edge_q;

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: rdata = cnt_q;
      2'd1: begin
        rdata[5:4] = mode_q;
        rdata[6]   = edge_q;
        rdata[7]   = stop_q;
      end
      2'd2: rdata = cap_q;
      default: rdata = latch_q;
    endcase
  end
endmodule

module rld_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         we,
  input logic [1:0]   addr,
  input logic [W-1:0] rdata,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cap,
  input logic [W-1:0] latch,
  input logic [1:0]   mode,
  input logic         stop,
  input logic         irq_uf,
  input logic         irq_edge
);
  // R5
  uf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_uf |-> ($past(cnt) == '0 && cnt == $past(latch)));

  // R7
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_edge && $past(mode[0]) && !$past(stop)) |-> (cap == $past(cnt) && cnt == $past(latch)));

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop) && !$past(we && addr == 2'd0)) |-> $stable(cnt));

  // R3
  ctrl_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd1) |-> (rdata[3:0] == 4'd0 && rdata[W-1:8] == '0));
endmodule

bind rld_timer rld_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .rdata(rdata),
  .cnt(cnt_q), .cap(cap_q), .latch(latch_q), .mode(mode_q), .stop(stop_q),
  .irq_uf(irq_uf), .irq_edge(irq_edge)
);

// File: tb/rld_timer_bench.sv
`timescale 1ns/1ps
module rld_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ext_pin = 1'b0;
  logic        irq_uf, irq_edge;

  int checks = 0, fails = 0;
  int uf_seen = 0, edge_seen = 0;
  int t = 0;

  rld_timer u_rld_timer (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_pin(ext_pin), .irq_uf(irq_uf), .irq_edge(irq_edge)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    #2;
    if (rst_n && irq_uf)   uf_seen++;
    if (rst_n && irq_edge) edge_seen++;
  end

  function automatic int timer_val(int n, int d);
    return n - (d % (n + 1));
  endfunction

  function automatic int ticks_in(int a, int b);
    if (b < a) return 0;
    return b / 16 - (a - 1) / 16;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    t = 0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
    t += n;
  endtask

  task automatic pin_pulse();
    ext_pin = 1'b1; wait_cyc(4);
    ext_pin = 1'b0; wait_cyc(4);
  endtask

  task automatic done();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    done();
  end

  initial begin
    int v, n, nc, u0, e0;
    void'($urandom(32'h5eed_7113));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1", "counter", v, 16'hFFFF);
    rd(2'd1, v); chk("R1", "control", v, 0);
    rd(2'd2, v); chk("R1", "capture", v, 0);
    rd(2'd3, v); chk("R1", "reload", v, 16'hFFFF);
    chk("R1", "irq lines", {irq_uf, irq_edge}, 0);

    // R3 control layout, unused bits zero
    wr(2'd1, 16'hFFFF);
    rd(2'd1, v); chk("R3", "control readback", v, 16'h00F0);

    // R11 halted reload write loads counter; R2 address map
    wr(2'd0, 16'h1234);
    rd(2'd0, v); chk("R11", "halted load counter", v, 16'h1234);
    rd(2'd3, v); chk("R2", "reload readback", v, 16'h1234);

    // R4 R5 random timer runs
    for (int i = 0; i < 8; i++) begin
      n  = (i == 0) ? 0 : int'($urandom % 8);
      nc = int'($urandom % 300);
      wr(2'd1, 16'h0080);
      wr(2'd0, 16'(n));
      u0 = uf_seen;
      wr(2'd1, 16'h0000);
      wait_cyc(nc);
      rd(2'd0, v); chk("R4", "timer count", v, timer_val(n, nc / 16));
      chk("R5", "underflow pulses", uf_seen - u0, (nc / 16) / (n + 1));
    end

    // R10 halt freezes
    wr(2'd1, 16'h0080);
    wr(2'd0, 16'd50);
    wr(2'd1, 16'h0000);
    wait_cyc(40);
    wr(2'd1, 16'h0080);
    rd(2'd0, v); chk("R10", "value at halt", v, 48);
    wait_cyc(100);
    rd(2'd0, v); chk("R10", "value held", v, 48);

    // R6 R11 event rising, running reload write
    wr(2'd0, 16'd3);
    u0 = uf_seen;
    wr(2'd1, 16'h0020);
    pin_pulse(); pin_pulse();
    rd(2'd0, v); chk("R6", "rising events", v, 1);
    wr(2'd0, 16'd9);
    rd(2'd0, v); chk("R11", "running write keeps counter", v, 1);
    rd(2'd3, v); chk("R11", "running write sets reload", v, 9);
    pin_pulse(); pin_pulse();
    rd(2'd0, v); chk("R11", "new reload used", v, 9);
    chk("R5", "event underflow", uf_seen - u0, 1);

    // R6 R9 event falling
    wr(2'd1, 16'h0080);
    wr(2'd0, 16'd100);
    e0 = edge_seen;
    wr(2'd1, 16'h0060);
    pin_pulse(); pin_pulse(); pin_pulse();
    rd(2'd0, v); chk("R6", "falling events", v, 97);
    chk("R9", "edge irq rising select", edge_seen - e0, 3);

    // R10 halted event input
    wr(2'd1, 16'h00E0);
    pin_pulse(); pin_pulse();
    rd(2'd0, v); chk("R10", "halted events", v, 97);

    // R7 period meter, rising edges
    wr(2'd1, 16'h0080);
    wr(2'd0, 16'hFFFF);
    e0 = edge_seen;
    wr(2'd1, 16'h0050);
    wait_cyc(20); ext_pin = 1'b1;
    wait_cyc(10);
    rd(2'd2, v); chk("R7", "first capture", v, 16'hFFFF - ticks_in(1, 22));
    ext_pin = 1'b0;
    wait_cyc(20);
    rd(2'd2, v); chk("R7", "capture held over falling", v, 16'hFFFF - ticks_in(1, 22));
    rd(2'd0, v); chk("R7", "count after reload", v, 16'hFFFF - ticks_in(24, 50));
    ext_pin = 1'b1;
    wait_cyc(10);
    rd(2'd2, v); chk("R7", "second capture", v, 16'hFFFF - ticks_in(24, 52));
    chk("R9", "edge irq period", edge_seen - e0, 2);

    // R8 width meter, both edges with select 0
    wr(2'd1, 16'h0080);
    ext_pin = 1'b0;
    wait_cyc(5);
    wr(2'd0, 16'hFFFF);
    e0 = edge_seen;
    wr(2'd1, 16'h0030);
    wait_cyc(40); ext_pin = 1'b1;
    wait_cyc(10);
    rd(2'd2, v); chk("R8", "rise capture", v, 16'hFFFF - ticks_in(1, 42));
    wait_cyc(10); ext_pin = 1'b0;
    wait_cyc(10);
    rd(2'd2, v); chk("R8", "fall capture", v, 16'hFFFF - ticks_in(44, 62));
    chk("R9", "edge irq width", edge_seen - e0, 2);

    done();
  end
endmodule